// File: doc/BRIEF.md
# Reference Input Qualification Monitor

The monitor watches a bank of reference clock inputs and decides, for each one, whether it is fit to serve as a timing source. Each reference supplies two inputs. The first is an activity-good flag. The second is a signed frequency-offset word that an upstream measurement stage produces. The monitor compares the magnitude of that offset against two programmable limits. The inner qualification limit must be met for a programmable dwell before a reference is granted. The outer disqualification limit revokes a qualified reference at once.

Offsets between the two limits change nothing, which gives hysteresis. A per-reference alarm flags references that have lost activity or have been disqualified. It stays set until the reference earns qualification again. Each reference also keeps a saturating age counter of timebase ticks since it last qualified. A reference selector downstream uses this age to break ties between references of equal priority. The qualified flags can be read as two bytes through a byte-select read port.

Top module: `ref_qual_monitor`

## Requirements
- R1: After reset, every reference is unqualified with its alarm clear and its age at zero. The references are independent: the inputs of one reference never change the state of another.
- R2: A qualified reference is disqualified on the next clock edge when its activity flag is low or its offset magnitude exceeds the disqualification limit.
- R3: An unqualified reference qualifies on the timebase tick that follows `qual_time_i` earlier in-range ticks, which is the (qual_time_i+1)-th consecutive in-range tick. In range means the activity flag is high and the offset magnitude is at most the qualification limit.
- R4: While a reference is unqualified, its dwell count returns to zero whenever the offset magnitude exceeds the qualification limit or its activity flag is low.
- R5: A qualified reference whose offset magnitude lies between the qualification limit and the disqualification limit (inclusive of the disqualification limit) stays qualified.
- R6: The alarm of a reference is set on the edge after its activity flag is sampled low, and also on disqualification. It stays set while the reference is unqualified and clears on the same edge that the reference qualifies.
- R7: `rd_data_o` returns qualified flags 7..0 in bits 7..0 when `rd_sel_i` is 0. When `rd_sel_i` is 1 it returns flags 11..8 in bits 3..0, with zeros above.
- R8: The age of a qualified reference advances by one on each tick and saturates at 2^AGE_W-1. It is zero while the reference is unqualified and starts from zero on qualification.
- R9: The offset is two's complement and is judged by magnitude. The most negative code has magnitude 2^(OFS_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe for dwell and age counting |
| act_good_i | input | NUM_REFS | Activity-good flag per reference |
| ofs_i | input | NUM_REFS*OFS_W | Signed offset per reference, reference k in bits [k*OFS_W +: OFS_W] |
| qual_lim_i | input | OFS_W | Qualification magnitude limit (unsigned) |
| disq_lim_i | input | OFS_W | Disqualification magnitude limit (unsigned, at least qual_lim_i) |
| qual_time_i | input | TMR_W | Dwell length in ticks |
| rd_sel_i | input | 1 | Status byte select |
| rd_data_o | output | 8 | Selected byte of qualified flags |
| qual_o | output | NUM_REFS | Qualified flag per reference |
| alarm_o | output | NUM_REFS | Alarm flag per reference |
| age_o | output | NUM_REFS*AGE_W | Age since qualification per reference |

## Verification
A corrupted dwell count shows at the ports as a qualified flag that rises one or more ticks early or late. The model exposes this on the first qualification after the fault. A stuck comparison shows up either as a missed disqualification on the next edge or as a reference that drops while its offset is in the hysteresis band. Age and alarm faults appear on the very next tick or edge, because both are compared with the model on every clock. Offsets are driven exactly at both limits and at the most negative code, so off-by-one errors in the limits are visible.

// File: rtl/ref_qual_pkg.sv
package ref_qual_pkg;
  localparam int unsigned RD_BYTE_W = 8;
  localparam int unsigned RD_BYTES  = 2;
  localparam int unsigned MAX_REFS  = RD_BYTE_W * RD_BYTES;

  typedef enum logic {
    RD_LO = 1'b0,
    RD_HI = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/ref_qual_cmp.sv
module ref_qual_cmp #(
  parameter int unsigned OFS_W = 16
) (
  input  logic             act_good_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [OFS_W-1:0] qual_lim_i,
  input  logic [OFS_W-1:0] disq_lim_i,
  output logic             in_qual_o,
  output logic             out_disq_o
);
  logic [OFS_W-1:0] mag;

  // unsigned view keeps the most negative code exact
  assign mag        = ofs_i[OFS_W-1] ? (~ofs_i + 1'b1) : ofs_i;
  assign in_qual_o  = act_good_i && (mag <= qual_lim_i);
  assign out_disq_o = !act_good_i || (mag > disq_lim_i);
endmodule

// File: rtl/ref_qual_chan.sv
module ref_qual_chan #(
  parameter int unsigned OFS_W = 16,
  parameter int unsigned TMR_W = 16,
  parameter int unsigned AGE_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             act_good_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [OFS_W-1:0] qual_lim_i,
  input  logic [OFS_W-1:0] disq_lim_i,
  input  logic [TMR_W-1:0] qual_time_i,
  output logic             qual_o,
  output logic             alarm_o,
  output logic [AGE_W-1:0] age_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic             in_qual, out_disq;
  logic             qual_q, alarm_q;
  logic [TMR_W-1:0] dwell_q;
  logic [AGE_W-1:0] age_q;

  ref_qual_cmp #(.OFS_W(OFS_W)) u_cmp (
    .act_good_i (act_good_i),
    .ofs_i      (ofs_i),
    .qual_lim_i (qual_lim_i),
    .disq_lim_i (disq_lim_i),
    .in_qual_o  (in_qual),
    .out_disq_o (out_disq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qual_q  <= 1'b0;
      alarm_q <= 1'b0;
      dwell_q <= '0;
      age_q   <= '0;
    end else if (qual_q) begin
      if (out_disq) begin
        qual_q  <= 1'b0;
        alarm_q <= 1'b1;
        age_q   <= '0;
      end else if (tick_i && age_q != AGE_MAX) begin
        age_q <= age_q + 1'b1;
      end
    end else begin
      if (!act_good_i) alarm_q <= 1'b1;
      if (!in_qual) begin
        dwell_q <= '0;
      end else if (tick_i) begin
        if (dwell_q >= qual_time_i) begin
          qual_q  <= 1'b1;
          alarm_q <= 1'b0;
          dwell_q <= '0;
          age_q   <= '0;
        end else begin
          dwell_q <= dwell_q + 1'b1;
        end
      end
    end
  end

  assign qual_o  = qual_q;
  assign alarm_o = alarm_q;
  assign age_o   = age_q;
endmodule

// File: rtl/ref_qual_rdmux.sv
module ref_qual_rdmux
  import ref_qual_pkg::*;
#(
  parameter int unsigned NUM_REFS = 12
) (
  input  logic [NUM_REFS-1:0]  qual_i,
  input  logic                 rd_sel_i,
  output logic [RD_BYTE_W-1:0] rd_data_o
);
  logic [MAX_REFS-1:0] padded;

  always_comb begin
    padded = '0;
    padded[NUM_REFS-1:0] = qual_i;
  end

  always_comb begin
    unique case (rd_sel_e'(rd_sel_i))
      RD_HI:   rd_data_o = padded[RD_BYTE_W +: RD_BYTE_W];
      default: rd_data_o = padded[0 +: RD_BYTE_W];
    endcase
  end
endmodule

// File: rtl/ref_qual_monitor.sv
module ref_qual_monitor
  import ref_qual_pkg::*;
#(
  parameter int unsigned NUM_REFS = 12,
  parameter int unsigned OFS_W    = 16,
  parameter int unsigned TMR_W    = 16,
  parameter int unsigned AGE_W    = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic [NUM_REFS-1:0]       act_good_i,
  input  logic [NUM_REFS*OFS_W-1:0] ofs_i,
  input  logic [OFS_W-1:0]          qual_lim_i,
  input  logic [OFS_W-1:0]          disq_lim_i,
  input  logic [TMR_W-1:0]          qual_time_i,
  input  logic                      rd_sel_i,
  output logic [RD_BYTE_W-1:0]      rd_data_o,
  output logic [NUM_REFS-1:0]       qual_o,
  output logic [NUM_REFS-1:0]       alarm_o,
  output logic [NUM_REFS*AGE_W-1:0] age_o
);
  for (genvar k = 0; k < NUM_REFS; k++) begin : g_chan
    ref_qual_chan #(
      .OFS_W (OFS_W),
      .TMR_W (TMR_W),
      .AGE_W (AGE_W)
    ) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .act_good_i  (act_good_i[k]),
      .ofs_i       (ofs_i[k*OFS_W +: OFS_W]),
      .qual_lim_i  (qual_lim_i),
      .disq_lim_i  (disq_lim_i),
      .qual_time_i (qual_time_i),
      .qual_o      (qual_o[k]),
      .alarm_o     (alarm_o[k]),
      .age_o       (age_o[k*AGE_W +: AGE_W])
    );
  end

  ref_qual_rdmux #(.NUM_REFS(NUM_REFS)) u_rdmux (
    .qual_i    (qual_o),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/ref_qual_chk.sv
module ref_qual_chk #(
  parameter int unsigned NUM_REFS = 12,
  parameter int unsigned OFS_W    = 16,
  parameter int unsigned TMR_W    = 16,
  parameter int unsigned AGE_W    = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      tick_i,
  input logic [NUM_REFS-1:0]       act_good_i,
  input logic [NUM_REFS*OFS_W-1:0] ofs_i,
  input logic [OFS_W-1:0]          disq_lim_i,
  input logic                      rd_sel_i,
  input logic [7:0]                rd_data_o,
  input logic [NUM_REFS-1:0]       qual_o,
  input logic [NUM_REFS-1:0]       alarm_o,
  input logic [NUM_REFS*AGE_W-1:0] age_o
);
  logic [15:0] qual_pad;
  always_comb begin
    qual_pad = '0;
    qual_pad[NUM_REFS-1:0] = qual_o;
  end

  // R7
  rd_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o == (rd_sel_i ? qual_pad[15:8] : qual_pad[7:0]));

  for (genvar k = 0; k < NUM_REFS; k++) begin : g_chk
    logic signed [OFS_W-1:0] ofs_s;
    logic [OFS_W:0]          mag;
    logic                    beyond;
    assign ofs_s  = ofs_i[k*OFS_W +: OFS_W];
    assign mag    = (ofs_s < 0) ? (OFS_W+1)'(-$signed({ofs_s[OFS_W-1], ofs_s}))
                                : (OFS_W+1)'(ofs_s);
    assign beyond = !act_good_i[k] || (mag > {1'b0, disq_lim_i});

    // R2
    disq_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (qual_o[k] && beyond) |=> !qual_o[k]);
    // R5
    hold_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (qual_o[k] && !beyond) |=> qual_o[k]);
    // R3
    qual_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(qual_o[k]) |-> $past(tick_i));
    // R6
    alarm_on_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_good_i[k] |=> alarm_o[k]);
    // R6
    alarm_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(qual_o[k]) |-> !alarm_o[k]);
    // R8
    age_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !qual_o[k] |-> age_o[k*AGE_W +: AGE_W] == '0);
  end
endmodule

bind ref_qual_monitor ref_qual_chk #(
  .NUM_REFS (NUM_REFS),
  .OFS_W    (OFS_W),
  .TMR_W    (TMR_W),
  .AGE_W    (AGE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .act_good_i (act_good_i),
  .ofs_i      (ofs_i),
  .disq_lim_i (disq_lim_i),
  .rd_sel_i   (rd_sel_i),
  .rd_data_o  (rd_data_o),
  .qual_o     (qual_o),
  .alarm_o    (alarm_o),
  .age_o      (age_o)
);

// File: tb/ref_qual_monitor_bench.sv
`timescale 1ns/1ps
module ref_qual_monitor_bench;
  localparam int N     = 12;
  localparam int OW    = 16;
  localparam int TW    = 8;
  localparam int AW    = 4;
  localparam int AMAX  = 15;
  localparam int QLIM  = 100;
  localparam int DLIM  = 300;
  localparam int QTIME = 3;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              tick = 0;
  logic [N-1:0]      act = '0;
  logic signed [OW-1:0] ofs [N];
  logic [N*OW-1:0]   ofs_flat;
  logic              rd_sel = 0;
  logic [7:0]        rd_data;
  logic [N-1:0]      qual, alarm;
  logic [N*AW-1:0]   age;

  int errors = 0, checks = 0;
  bit done = 0;
  int m_q[N], m_a[N], m_t[N], m_age[N];

  always #5 clk = ~clk;

  always_comb for (int k = 0; k < N; k++) ofs_flat[k*OW +: OW] = ofs[k];

  ref_qual_monitor #(.NUM_REFS(N), .OFS_W(OW), .TMR_W(TW), .AGE_W(AW)) u_ref_qual_monitor (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .act_good_i(act), .ofs_i(ofs_flat),
    .qual_lim_i(16'(QLIM)), .disq_lim_i(16'(DLIM)), .qual_time_i(8'(QTIME)),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .qual_o(qual), .alarm_o(alarm), .age_o(age));

  task automatic check(input string tag, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic model_step();
    for (int k = 0; k < N; k++) begin
      int mg = (ofs[k] < 0) ? -int'(ofs[k]) : int'(ofs[k]);   // R9 magnitude
      bit inq = act[k] && mg <= QLIM;
      bit out = !act[k] || mg > DLIM;
      if (m_q[k] != 0) begin
        if (out) begin m_q[k] = 0; m_a[k] = 1; m_age[k] = 0; end
        else if (tick && m_age[k] < AMAX) m_age[k]++;
      end else begin
        if (!act[k]) m_a[k] = 1;
        if (!inq) m_t[k] = 0;
        else if (tick) begin
          if (m_t[k] >= QTIME) begin m_q[k] = 1; m_a[k] = 0; m_t[k] = 0; m_age[k] = 0; end
          else m_t[k]++;
        end
      end
    end
  endtask

  task automatic compare();
    int eq = 0, ea = 0, er;
    for (int k = 0; k < N; k++) begin
      eq |= m_q[k] << k;
      ea |= m_a[k] << k;
      check($sformatf("R8 age ref%0d", k), int'(age[k*AW +: AW]), m_age[k]);
    end
    check("R1/R2/R3/R4/R5/R9 qual", int'(qual), eq);
    check("R6 alarm", int'(alarm), ea);
    er = rd_sel ? ((eq >> 8) & 8'h0f) : (eq & 8'hff);
    check("R7 rd_data", int'(rd_data), er);
  endtask

  task automatic step(input bit tk);
    tick = tk;
    rd_sel = ~rd_sel;
    @(posedge clk); #1;
    model_step();
    compare();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin ofs[k] = '0; m_q[k] = 0; m_a[k] = 0; m_t[k] = 0; m_age[k] = 0; end
    act = '1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset qual", int'(qual), 0);
    check("R1 reset alarm", int'(alarm), 0);
    check("R1 reset age", int'(age), 0);
    rst_n = 1;
    @(negedge clk);
    // R3 dwell: qualify on 4th in-range tick, ticks every other cycle
    for (int c = 0; c < 12; c++) step(c % 2 == 0);
    // R8 saturation
    for (int c = 0; c < 40; c++) step(1);
    // R5 band, R2 beyond, R9 edges
    ofs[3] = 16'sd300; ofs[4] = 16'sd301; ofs[5] = -16'sd300; ofs[6] = -16'sd32768;
    for (int c = 0; c < 4; c++) step(1);
    // R6 activity loss; R4 dwell restart while unqualified
    act[7] = 0; step(1); step(0); act[7] = 1;
    for (int c = 0; c < 3; c++) step(1);
    ofs[7] = 16'sd150; step(1);
    ofs[7] = -16'sd100; ofs[4] = 16'sd100;
    for (int c = 0; c < 8; c++) step(1);
    // R1 independence and mixed random traffic
    for (int c = 0; c < 3000; c++) begin
      for (int k = 0; k < N; k++) begin
        if ($urandom_range(7) == 0) begin
          case ($urandom_range(9))
            0: ofs[k] = 16'sd0;
            1: ofs[k] = 16'sd100;
            2: ofs[k] = -16'sd101;
            3: ofs[k] = 16'sd200;
            4: ofs[k] = -16'sd300;
            5: ofs[k] = 16'sd301;
            6: ofs[k] = -16'sd32768;
            7: ofs[k] = 16'sd32767;
            default: ofs[k] = 16'($signed($urandom_range(200)) - 100);
          endcase
        end
        if (act[k] && $urandom_range(59) == 0) act[k] = 0;
        else if (!act[k] && $urandom_range(3) == 0) act[k] = 1;
      end
      step($urandom_range(1) == 1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule